// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This block is the decision logic of a single-slot dispenser that takes nickels and dimes. A coin sensor delivers a one-cycle strobe per coin on one of two inputs. The controller keeps a running credit in a small state register. When the credit reaches the item price of 15 cents, it raises a release strobe for exactly one cycle and then starts over from zero. Overpayment is not refunded: any total of 15 cents or more collapses into the single full state.

The controller is a Moore machine with four named credit states. EMPTY (0 cents, code 2'b00) goes to FIVE on a nickel and to TEN on a dime. FIVE (5 cents, 2'b01) goes to TEN on a nickel and to FULL on a dime. TEN (10 cents, 2'b10) goes to FULL on either coin. FULL (15 cents, 2'b11) goes back to EMPTY unconditionally. Every credit state below FULL holds on an idle cycle or on an illegal cycle. A cycle with both strobes high is illegal: the credit is left alone, and a one-cycle flag reports it.

Top module: `coin_vend_ctrl`

## Requirements
- R1: A synchronous reset puts the credit in EMPTY (2'b00), with the release strobe and the illegal flag low on the cycle after reset is sampled.
- R2: The release strobe is high exactly while the credit register holds FULL (2'b11) and depends on no input.
- R3: Below FULL, a nickel strobe alone raises the credit by 5 cents and a dime strobe alone by 10 cents, with the new credit taking effect at the clock edge that samples the strobe.
- R4: A deposit that would bring the credit to 15 cents or more lands in FULL with no change given, so a dime at TEN gives the same single release as a nickel at TEN.
- R5: Below FULL, a cycle with neither strobe leaves the credit unchanged, however many such cycles pass.
- R6: The release strobe rises on the cycle after the edge that reaches FULL and lasts one cycle.
- R7: From FULL the next edge always returns to EMPTY, and any coin strobe sampled during that FULL cycle is discarded.
- R8: When both strobes are high in one cycle, the credit is not changed (below FULL), and the illegal flag is high for exactly the following cycle.
- R9: Each of the deposit orders nickel-nickel-nickel, nickel-dime, dime-nickel, dime-dime and nickel-nickel-dime yields exactly one release pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| nickel_i | input | 1 | One-cycle strobe for a 5-cent coin |
| dime_i | input | 1 | One-cycle strobe for a 10-cent coin |
| vend_open_o | output | 1 | Release strobe, high while credit is FULL |
| illegal_o | output | 1 | One-cycle flag after both strobes were sampled together |

## Verification
The five deposit orders separate the paths into FULL: by nickel from TEN, by dime from FIVE, and by a dime at TEN that overshoots and must still saturate. Idle gaps between coins test that credit is held rather than leaked. A dual-strobe cycle placed mid-sequence tells a held credit apart from one that wrongly took either coin. A coin timed onto the FULL cycle, followed by a dime alone, shows that the discarded coin did not carry into the next purchase. A reset in the middle of a purchase shows that partial credit is thrown away.

// File: rtl/coin_vend_pkg.sv
package coin_vend_pkg;

    localparam int CREDIT_W     = 2;
    localparam int SUM_W        = CREDIT_W + 1;
    localparam int NICKEL_UNITS = 1;
    localparam int DIME_UNITS   = 2;
    localparam int FULL_UNITS   = 3;

    typedef enum logic [CREDIT_W-1:0] {
        CR_EMPTY = 2'b00,
        CR_FIVE  = 2'b01,
        CR_TEN   = 2'b10,
        CR_FULL  = 2'b11
    } credit_e;

    typedef enum logic [1:0] {
        COIN_NONE   = 2'b00,
        COIN_NICKEL = 2'b01,
        COIN_DIME   = 2'b10,
        COIN_BOTH   = 2'b11
    } coin_e;

    function automatic credit_e sat_credit(input logic [SUM_W-1:0] units);
        if (units >= SUM_W'(FULL_UNITS)) begin
            return CR_FULL;
        end
        return credit_e'(units[CREDIT_W-1:0]);
    endfunction

endpackage

// File: rtl/coin_classify.sv
module coin_classify
    import coin_vend_pkg::*;
(
    input  logic  nickel,
    input  logic  dime,
    output coin_e kind
);

    always_comb begin
        unique case ({dime, nickel})
            2'b00:   kind = COIN_NONE;
            2'b01:   kind = COIN_NICKEL;
            2'b10:   kind = COIN_DIME;
            default: kind = COIN_BOTH;
        endcase
    end

endmodule

// File: rtl/credit_step.sv
module credit_step
    import coin_vend_pkg::*;
(
    input  credit_e cur,
    input  coin_e   kind,
    output credit_e nxt
);

    logic [SUM_W-1:0] base;

    assign base = {1'b0, cur};

    always_comb begin
        nxt = cur;
        unique case (cur)
            CR_FULL: nxt = CR_EMPTY;
            CR_EMPTY, CR_FIVE, CR_TEN: begin
                unique case (kind)
                    COIN_NICKEL: nxt = sat_credit(base + SUM_W'(NICKEL_UNITS));
                    COIN_DIME:   nxt = sat_credit(base + SUM_W'(DIME_UNITS));
                    COIN_NONE,
                    COIN_BOTH:   nxt = cur;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/credit_reg.sv
module credit_reg
    import coin_vend_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  credit_e nxt,
    input  coin_e   kind,
    output credit_e credit_q,
    output logic    illegal_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            credit_q  <= CR_EMPTY;
            illegal_q <= 1'b0;
        end else begin
            credit_q  <= nxt;
            illegal_q <= (kind == COIN_BOTH);
        end
    end

endmodule

// File: rtl/vend_decode.sv
module vend_decode
    import coin_vend_pkg::*;
(
    input  credit_e cur,
    output logic    open
);

    always_comb begin
        unique case (cur)
            CR_FULL:                   open = 1'b1;
            CR_EMPTY, CR_FIVE, CR_TEN: open = 1'b0;
        endcase
    end

endmodule

// File: rtl/coin_vend_ctrl.sv
module coin_vend_ctrl
    import coin_vend_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic nickel_i,
    input  logic dime_i,
    output logic vend_open_o,
    output logic illegal_o
);

    coin_e   coin_kind;
    credit_e credit_q;
    credit_e credit_nxt;

    coin_classify u_classify (
        .nickel (nickel_i),
        .dime   (dime_i),
        .kind   (coin_kind)
    );

    credit_step u_step (
        .cur  (credit_q),
        .kind (coin_kind),
        .nxt  (credit_nxt)
    );

    credit_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .nxt       (credit_nxt),
        .kind      (coin_kind),
        .credit_q  (credit_q),
        .illegal_q (illegal_o)
    );

    vend_decode u_decode (
        .cur  (credit_q),
        .open (vend_open_o)
    );

endmodule

// File: rtl/coin_vend_chk.sv
module coin_vend_chk
    import coin_vend_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input logic    nickel_i,
    input logic    dime_i,
    input logic    vend_open_o,
    input logic    illegal_o,
    input credit_e credit
);

    p_reset_empty_r1: assert property (@(posedge clk)
        rst |=> (credit == CR_EMPTY) && !vend_open_o && !illegal_o);

    p_open_full_r2: assert property (@(posedge clk) disable iff (rst)
        vend_open_o |-> (credit == CR_FULL));

    p_dime_step_r3: assert property (@(posedge clk) disable iff (rst)
        (credit == CR_EMPTY && dime_i && !nickel_i) |=> (credit == CR_TEN));

    p_nickel_step_r3: assert property (@(posedge clk) disable iff (rst)
        (credit == CR_FIVE && nickel_i && !dime_i) |=> (credit == CR_TEN));

    p_saturate_r4: assert property (@(posedge clk) disable iff (rst)
        (credit == CR_TEN && dime_i && !nickel_i) |=> vend_open_o);

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (credit != CR_FULL && !nickel_i && !dime_i) |=> $stable(credit));

    p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        vend_open_o |=> !vend_open_o);

    p_back_empty_r7: assert property (@(posedge clk) disable iff (rst)
        (credit == CR_FULL) |=> (credit == CR_EMPTY));

    p_both_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (credit != CR_FULL && nickel_i && dime_i) |=> $stable(credit) && illegal_o);

    p_flag_cause_r8: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> $past(nickel_i && dime_i));

endmodule

bind coin_vend_ctrl coin_vend_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .nickel_i    (nickel_i),
    .dime_i      (dime_i),
    .vend_open_o (vend_open_o),
    .illegal_o   (illegal_o),
    .credit      (credit_q)
);

// File: tb/test_coin_vend_ctrl.sv
module test_coin_vend_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        logic  open;
        logic  ill;
        string tag;
    } expect_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nickel_i = 1'b0;
    logic dime_i = 1'b0;
    logic vend_open_o;
    logic illegal_o;

    int      total = 0;
    int      bad = 0;
    int      ref_cents = 0;
    int      open_cnt = 0;
    expect_t sb_q[$];

    coin_vend_ctrl i_coin_vend_ctrl (
        .clk         (clk),
        .rst         (rst),
        .nickel_i    (nickel_i),
        .dime_i      (dime_i),
        .vend_open_o (vend_open_o),
        .illegal_o   (illegal_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Driver: one coin cycle, expected outputs after the next edge go to the scoreboard
    task automatic apply(input logic n, input logic d, input string tag);
        expect_t e;
        @(negedge clk);
        nickel_i = n;
        dime_i   = d;
        if (ref_cents >= 15) begin
            ref_cents = 0;
        end else if (!(n && d)) begin
            ref_cents = ref_cents + (n ? 5 : 0) + (d ? 10 : 0);
            if (ref_cents > 15) ref_cents = 15;
        end
        e.open = (ref_cents == 15);
        e.ill  = n && d;
        e.tag  = tag;
        sb_q.push_back(e);
    endtask

    task automatic idle(input int cycles, input string tag);
        for (int i = 0; i < cycles; i++) apply(1'b0, 1'b0, tag);
    endtask

    // Monitor: pops one expectation per edge, just after the edge
    always @(posedge clk) begin
        #1;
        if (vend_open_o) open_cnt++;
        if (sb_q.size() > 0) begin
            expect_t e;
            e = sb_q.pop_front();
            total++;
            if (vend_open_o !== e.open || illegal_o !== e.ill) begin
                bad++;
                $display("FAIL %s: open=%0b illegal=%0b, expected open=%0b illegal=%0b",
                         e.tag, vend_open_o, illegal_o, e.open, e.ill);
            end
        end
    end

    task automatic check_reset(input string tag);
        @(negedge clk);
        total++;
        if (vend_open_o !== 1'b0 || illegal_o !== 1'b0) begin
            bad++;
            $display("FAIL %s: open=%0b illegal=%0b, expected open=0 illegal=0",
                     tag, vend_open_o, illegal_o);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        nickel_i = 1'b0;
        dime_i   = 1'b0;
        rst      = 1'b1;
        @(negedge clk);
        rst       = 1'b0;
        ref_cents = 0;
        check_reset("R1 reset clears outputs");
    endtask

    task automatic expect_pulses(input int want, input string tag);
        @(negedge clk);
        total++;
        if (open_cnt != want) begin
            bad++;
            $display("FAIL %s: pulses=%0d, expected %0d", tag, open_cnt, want);
        end
        open_cnt = 0;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        bad++;
        $display("FAIL watchdog: run not finished, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_reset("R1 outputs low after reset");
        open_cnt = 0;

        // R9 / R3 / R4 / R6 / R7: each deposit order gives one release
        apply(1, 0, "R9 NNN"); apply(1, 0, "R9 NNN"); apply(1, 0, "R9 NNN");
        idle(3, "R7 NNN back to empty");
        expect_pulses(1, "R9 NNN");

        apply(1, 0, "R9 ND"); apply(0, 1, "R3 dime from five");
        idle(3, "R6 ND pulse");
        expect_pulses(1, "R9 ND");

        apply(0, 1, "R9 DN"); apply(1, 0, "R3 nickel from ten");
        idle(3, "R6 DN pulse");
        expect_pulses(1, "R9 DN");

        apply(0, 1, "R9 DD"); apply(0, 1, "R4 dime at ten saturates");
        idle(3, "R6 DD pulse");
        expect_pulses(1, "R4 DD");

        apply(1, 0, "R9 NND"); apply(1, 0, "R9 NND"); apply(0, 1, "R4 NND saturates");
        idle(3, "R6 NND pulse");
        expect_pulses(1, "R9 NND");

        // R5: idle gaps hold credit
        apply(1, 0, "R5 gap"); idle(4, "R5 hold five");
        apply(1, 0, "R5 gap"); idle(5, "R5 hold ten");
        apply(1, 0, "R5 reach full"); idle(2, "R5 after");
        expect_pulses(1, "R5 held credit");

        // R8: both strobes at zero and mid-sequence
        apply(1, 1, "R8 both at empty"); idle(1, "R8 flag one cycle");
        apply(1, 0, "R8 seq"); apply(1, 1, "R8 both at five");
        apply(1, 0, "R8 seq"); idle(1, "R8 still ten");
        expect_pulses(0, "R8 credit held");
        apply(1, 0, "R8 completes"); idle(2, "R8 after");
        expect_pulses(1, "R8 one release");

        // R7: coin during the full cycle is discarded
        apply(1, 0, "R7 setup"); apply(0, 1, "R7 full");
        apply(0, 1, "R7 dime in full dropped");
        apply(0, 1, "R7 dime from empty");
        idle(2, "R7 ten only");
        expect_pulses(1, "R7 dropped coin");
        apply(1, 0, "R7 nickel completes"); idle(2, "R7 after");
        expect_pulses(1, "R7 next purchase");

        // R1: reset in mid purchase clears partial credit
        apply(0, 1, "R1 partial");
        idle(1, "R1 partial");
        do_reset();
        apply(1, 0, "R1 after reset"); apply(1, 0, "R1 after reset");
        idle(2, "R1 only ten");
        expect_pulses(0, "R1 credit cleared");
        apply(1, 0, "R1 finish"); idle(2, "R1 finish");
        expect_pulses(1, "R2 release after reset");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule